// File: doc/BRIEF.md
# Receive Channel Supervisor

This block supervises a set of descriptor-driven receive channels. For each channel it keeps the receiver supplied with buffer descriptors. It collects the descriptors the receiver has finished with and keeps a count of descriptors that are still outstanding. It also watches the alignment and overflow status lines. When a fault occurs, the channel goes through a recovery sequence that drains the outstanding descriptors, flushes the buffer ring and then refills it. It talks to three neighbours: the receiver's status and descriptor queues, the ring pointer manager (reserve, commit and flush requests), and a single error indicator shared by all channels.

Each channel is in one of four states: idle, boot, run or recover. The channels share one round-robin pointer. In each clock cycle only the channel under the pointer takes a supervisor step, and that step performs at most one action. Start and stop commands act at once on their channel and do not wait for the pointer. Each channel keeps three sticky event bits, which a single read port returns and clears in the same cycle.

Top module: `rx_chan_supervisor`

## Requirements
- R1: A start on a channel (with no stop) drives `rx_en`=1 and `rx_mode`=2'b11 (multiframe-aligned) from the next cycle, and pulses `ovfl_clr` in the same cycle. It also puts the channel in boot and zeroes its outstanding count and event bits. A stop drives `rx_en`=0 and `rx_mode`=0 from the next cycle and puts the channel in idle. When both are asserted, stop wins.
- R2: In a step where `done_valid` is high, the channel pulses `done_pop` and `ring_commit` and decrements its outstanding count (never below zero). If the 2-bit CRC status is not 2'b11, it also sets event bit 2 and raises an error. A completion takes precedence over every other step action.
- R3: In run with no completion pending, loss of `rx_aligned` moves the channel to recover, sets event bit 0 and raises an error. Otherwise, `rx_ovfl` high moves it to recover and sets event bit 1 without raising an error.
- R4: In recover, a step does nothing while the outstanding count is nonzero. When the count is zero, the step pulses `ring_flush` and moves the channel to boot.
- R5: In boot or run, a step with fewer than 4 descriptors outstanding and `ring_ok` high pulses `ring_reserve` and `bd_push` and increments the count.
- R6: In boot, a step that cannot refill pulses `ovfl_clr` and moves the channel to run.
- R7: An error event drives `err_ind` high from the next cycle, and it stays high for HOLD_CYCLES (1000) cycles after the last error event.
- R8: The `bd_slot` sent with `bd_push` equals the reserved frame offset `ring_ofs` shifted right by 4. It is 0 when no push is made.
- R9: `flag_data` shows the event bits of channel `flag_rd_ch` (bit 0 misalign, bit 1 overflow, bit 2 CRC). With `flag_rd` high these bits are cleared at the clock edge, but a bit set in that same cycle survives.
- R10: The round-robin pointer is 0 after reset and advances by one channel each cycle, wrapping around. A channel takes step actions only in cycles when the pointer names it.
- R11: A channel in idle takes no step: completions, alignment and overflow have no effect on its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | NUM_CH | Per-channel start command |
| stop | input | NUM_CH | Per-channel stop command |
| rx_aligned | input | NUM_CH | Receiver alignment status |
| rx_ovfl | input | NUM_CH | Receiver overflow status |
| done_valid | input | NUM_CH | A completed descriptor is at the head of the done queue |
| done_crc | input | 2*NUM_CH | CRC status bits of that completed descriptor |
| done_pop | output | NUM_CH | Pops the completed descriptor |
| ring_ok | input | NUM_CH | The ring can reserve one more multiframe |
| ring_ofs | input | FRAME_AW*NUM_CH | Frame offset of the next reservation |
| ring_reserve | output | NUM_CH | Reserve one multiframe |
| ring_commit | output | NUM_CH | Commit one multiframe |
| ring_flush | output | NUM_CH | Flush the ring |
| bd_push | output | NUM_CH | Submit a descriptor to the receiver |
| bd_slot | output | (FRAME_AW-4)*NUM_CH | Multiframe slot index of the descriptor |
| rx_en | output | NUM_CH | Receiver enable |
| rx_mode | output | 2*NUM_CH | Receiver mode (3 = multiframe aligned) |
| ovfl_clr | output | NUM_CH | Overflow-clear pulse |
| flag_rd | input | 1 | Read and clear event bits |
| flag_rd_ch | input | CH_W | Channel picked for the read |
| flag_data | output | 3 | Event bits of the picked channel |
| err_ind | output | 1 | Error indicator with hold time |

## Verification
The bench steers both channels through a long pseudo-random mix. The mix includes alignment drops, overflow pulses, completions with good and bad CRC, a ring that is sometimes full, event-bit reads, and stop/start commands that arrive at any point. The random mix exercises the step priorities and the recover drain, and it shows whether the work of one channel can leak into the pointer slot of the other. Reads in the same cycle as a flag set test whether a read clears before or after the set. A long quiet stretch after the last error separates the correct hold time from one that is a cycle off. A run with the ring always available fills each channel to its limit, which would expose an off-by-one in the descriptor cap.

// File: rtl/rx_sup_pkg.sv
// Package: shared state encoding and fixed constants of the receive supervisor.
package rx_sup_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BOOT    = 2'd1,
        ST_RUN     = 2'd2,
        ST_RECOVER = 2'd3
    } sup_state_e;

    localparam int          MF_SHIFT   = 4;      // frames per multiframe = 2**MF_SHIFT
    localparam logic [1:0]  MODE_MFA   = 2'b11;  // receiver mode: multiframe aligned
    localparam logic [1:0]  CRC_GOOD   = 2'b11;  // both CRC checks passed
    localparam int          FLAG_ALIGN = 0;
    localparam int          FLAG_OVFL  = 1;
    localparam int          FLAG_CRC   = 2;
endpackage

// File: rtl/rx_sup_rr.sv
// Round-robin pointer: names one channel per cycle, starting at 0 after reset.
// Assumes NUM_CH >= 2.
module rx_sup_rr #(
    parameter int NUM_CH = 2,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [NUM_CH-1:0] sel
);
    logic [CH_W-1:0] ptr;

    // Advance the pointer each cycle, wrapping at the last channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (ptr == CH_W'(NUM_CH - 1))
            ptr <= '0;
        else
            ptr <= ptr + 1'b1;
    end

    // Decode the pointer into a one-hot select.
    always_comb begin
        sel = '0;
        sel[ptr] = 1'b1;
    end
endmodule

// File: rtl/rx_sup_errhold.sv
// Error hold timer: reloads on any error event and keeps the indicator on
// until HOLD_CYCLES cycles pass with no new event.
module rx_sup_errhold #(
    parameter int HOLD_CYCLES = 1000,
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_evt,
    output logic err_ind
);
    logic [CNT_W-1:0] cnt;

    // Reload on an event, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (err_evt)
            cnt <= CNT_W'(HOLD_CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Indicator is on while the timer runs.
    assign err_ind = (cnt != '0);
endmodule

// File: rtl/rx_sup_chan.sv
// One channel supervisor: holds state, outstanding count, event bits and the
// receiver control word. A step (at most one action) is taken only when sel
// is high; start/stop act at once. Assumes the done queue only reports
// descriptors that were submitted; the count saturates at zero anyway.
module rx_sup_chan
    import rx_sup_pkg::*;
#(
    parameter int FRAME_AW     = 7,
    parameter int MAX_INFLIGHT = 4,
    localparam int SLOT_W = FRAME_AW - MF_SHIFT,
    localparam int IF_W   = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              start,
    input  logic              stop,
    input  logic              aligned,
    input  logic              ovfl,
    input  logic              done_valid,
    input  logic [1:0]        done_crc,
    input  logic              ring_ok,
    input  logic [FRAME_AW-1:0] ring_ofs,
    input  logic              flag_clr,
    output logic              done_pop,
    output logic              ring_reserve,
    output logic              ring_commit,
    output logic              ring_flush,
    output logic              bd_push,
    output logic [SLOT_W-1:0] bd_slot,
    output logic              rx_en,
    output logic [1:0]        rx_mode,
    output logic              ovfl_clr,
    output logic [2:0]        flags,
    output logic              err_evt
);
    sup_state_e      state, state_nx;
    logic [IF_W-1:0] inflight, inflight_nx;
    logic [2:0]      flag_set;
    logic            do_start, do_step;

    assign do_start = start & ~stop;
    assign do_step  = sel & ~start & ~stop & (state != ST_IDLE);

    // Step decision: completion first, then faults, drain/flush, refill, run entry.
    always_comb begin
        state_nx     = state;
        inflight_nx  = inflight;
        flag_set     = '0;
        err_evt      = 1'b0;
        done_pop     = 1'b0;
        ring_commit  = 1'b0;
        ring_reserve = 1'b0;
        ring_flush   = 1'b0;
        bd_push      = 1'b0;
        ovfl_clr     = do_start;
        if (stop) begin
            state_nx = ST_IDLE;
        end else if (start) begin
            state_nx    = ST_BOOT;
            inflight_nx = '0;
        end else if (do_step) begin
            if (done_valid) begin
                done_pop    = 1'b1;
                ring_commit = 1'b1;
                if (inflight != '0)
                    inflight_nx = inflight - 1'b1;
                if (done_crc != CRC_GOOD) begin
                    flag_set[FLAG_CRC] = 1'b1;
                    err_evt            = 1'b1;
                end
            end else if (state == ST_RUN && !aligned) begin
                state_nx             = ST_RECOVER;
                flag_set[FLAG_ALIGN] = 1'b1;
                err_evt              = 1'b1;
            end else if (state == ST_RUN && ovfl) begin
                state_nx            = ST_RECOVER;
                flag_set[FLAG_OVFL] = 1'b1;
            end else if (state == ST_RECOVER) begin
                if (inflight == '0) begin
                    ring_flush = 1'b1;
                    state_nx   = ST_BOOT;
                end
            end else if (inflight < IF_W'(MAX_INFLIGHT) && ring_ok) begin
                ring_reserve = 1'b1;
                bd_push      = 1'b1;
                inflight_nx  = inflight + 1'b1;
            end else if (state == ST_BOOT) begin
                ovfl_clr = 1'b1;
                state_nx = ST_RUN;
            end
        end
    end

    // Slot index of the reserved multiframe, zero when nothing is pushed.
    assign bd_slot = bd_push ? ring_ofs[FRAME_AW-1:MF_SHIFT] : '0;

    // State and outstanding-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            inflight <= '0;
        end else begin
            state    <= state_nx;
            inflight <= inflight_nx;
        end
    end

    // Sticky event bits: cleared by read or start, a same-cycle set survives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= ((flag_clr || do_start) ? 3'b000 : flags) | flag_set;
    end

    // Receiver control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en   <= 1'b0;
            rx_mode <= 2'b00;
        end else if (stop) begin
            rx_en   <= 1'b0;
            rx_mode <= 2'b00;
        end else if (start) begin
            rx_en   <= 1'b1;
            rx_mode <= MODE_MFA;
        end
    end
endmodule

// File: rtl/rx_chan_supervisor.sv
// Top: NUM_CH channel supervisors sharing one round-robin pointer, one error
// hold timer and one read-and-clear port for the event bits.
module rx_chan_supervisor
    import rx_sup_pkg::*;
#(
    parameter int NUM_CH       = 2,
    parameter int FRAME_AW     = 7,
    parameter int MAX_INFLIGHT = 4,
    parameter int HOLD_CYCLES  = 1000,
    localparam int SLOT_W = FRAME_AW - MF_SHIFT,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          start,
    input  logic [NUM_CH-1:0]          stop,
    input  logic [NUM_CH-1:0]          rx_aligned,
    input  logic [NUM_CH-1:0]          rx_ovfl,
    input  logic [NUM_CH-1:0]          done_valid,
    input  logic [2*NUM_CH-1:0]        done_crc,
    output logic [NUM_CH-1:0]          done_pop,
    input  logic [NUM_CH-1:0]          ring_ok,
    input  logic [FRAME_AW*NUM_CH-1:0] ring_ofs,
    output logic [NUM_CH-1:0]          ring_reserve,
    output logic [NUM_CH-1:0]          ring_commit,
    output logic [NUM_CH-1:0]          ring_flush,
    output logic [NUM_CH-1:0]          bd_push,
    output logic [SLOT_W*NUM_CH-1:0]   bd_slot,
    output logic [NUM_CH-1:0]          rx_en,
    output logic [2*NUM_CH-1:0]        rx_mode,
    output logic [NUM_CH-1:0]          ovfl_clr,
    input  logic                       flag_rd,
    input  logic [CH_W-1:0]            flag_rd_ch,
    output logic [2:0]                 flag_data,
    output logic                       err_ind
);
    logic [NUM_CH-1:0] sel;
    logic [NUM_CH-1:0] err_evt;
    logic [2:0]        flags [NUM_CH];

    rx_sup_rr #(.NUM_CH(NUM_CH)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        rx_sup_chan #(
            .FRAME_AW     (FRAME_AW),
            .MAX_INFLIGHT (MAX_INFLIGHT)
        ) u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .sel          (sel[i]),
            .start        (start[i]),
            .stop         (stop[i]),
            .aligned      (rx_aligned[i]),
            .ovfl         (rx_ovfl[i]),
            .done_valid   (done_valid[i]),
            .done_crc     (done_crc[2*i +: 2]),
            .ring_ok      (ring_ok[i]),
            .ring_ofs     (ring_ofs[FRAME_AW*i +: FRAME_AW]),
            .flag_clr     (flag_rd && (flag_rd_ch == CH_W'(i))),
            .done_pop     (done_pop[i]),
            .ring_reserve (ring_reserve[i]),
            .ring_commit  (ring_commit[i]),
            .ring_flush   (ring_flush[i]),
            .bd_push      (bd_push[i]),
            .bd_slot      (bd_slot[SLOT_W*i +: SLOT_W]),
            .rx_en        (rx_en[i]),
            .rx_mode      (rx_mode[2*i +: 2]),
            .ovfl_clr     (ovfl_clr[i]),
            .flags        (flags[i]),
            .err_evt      (err_evt[i])
        );
    end

    // Read port: event bits of the picked channel, zero for an unused index.
    always_comb begin
        flag_data = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (flag_rd_ch == CH_W'(i))
                flag_data = flags[i];
    end

    rx_sup_errhold #(.HOLD_CYCLES(HOLD_CYCLES)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_evt (|err_evt),
        .err_ind (err_ind)
    );
endmodule

// File: rtl/rx_chan_supervisor_chk.sv
// Checker: tracks outstanding descriptors per channel from the port pulses
// and checks the port-level rules. Bound to the top module below.
module rx_chan_supervisor_chk #(
    parameter int NUM_CH       = 2,
    parameter int MAX_INFLIGHT = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_CH-1:0]   start,
    input logic [NUM_CH-1:0]   stop,
    input logic [NUM_CH-1:0]   done_valid,
    input logic [2*NUM_CH-1:0] done_crc,
    input logic [NUM_CH-1:0]   done_pop,
    input logic [NUM_CH-1:0]   ring_ok,
    input logic [NUM_CH-1:0]   ring_reserve,
    input logic [NUM_CH-1:0]   ring_commit,
    input logic [NUM_CH-1:0]   ring_flush,
    input logic [NUM_CH-1:0]   bd_push,
    input logic [NUM_CH-1:0]   rx_en,
    input logic [2*NUM_CH-1:0] rx_mode,
    input logic                err_ind
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_c
        int cnt;

        // Outstanding count seen at the ports.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= 0;
            else if (start[i] && !stop[i])
                cnt <= 0;
            else
                cnt <= cnt + (bd_push[i] ? 1 : 0) - ((done_pop[i] && cnt > 0) ? 1 : 0);
        end

        AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= MAX_INFLIGHT); // R5
        AST_FLUSH_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
            ring_flush[i] |-> (cnt == 0)); // R4
        AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            done_pop[i] |-> (done_valid[i] && ring_commit[i])); // R2
        AST_PUSH_NEEDS_RING: assert property (@(posedge clk) disable iff (!rst_n)
            bd_push[i] |-> (ring_ok[i] && ring_reserve[i] && !done_pop[i])); // R5
        AST_BAD_CRC_ERR: assert property (@(posedge clk) disable iff (!rst_n)
            (done_pop[i] && done_crc[2*i +: 2] != 2'b11) |=> err_ind); // R7
        AST_MODE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
            rx_en[i] |-> (rx_mode[2*i +: 2] == 2'b11)); // R1
    end

    AST_ONE_STEPPER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_pop | ring_reserve | ring_flush)); // R10
endmodule

bind rx_chan_supervisor rx_chan_supervisor_chk #(
    .NUM_CH       (NUM_CH),
    .MAX_INFLIGHT (MAX_INFLIGHT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .stop         (stop),
    .done_valid   (done_valid),
    .done_crc     (done_crc),
    .done_pop     (done_pop),
    .ring_ok      (ring_ok),
    .ring_reserve (ring_reserve),
    .ring_commit  (ring_commit),
    .ring_flush   (ring_flush),
    .bd_push      (bd_push),
    .rx_en        (rx_en),
    .rx_mode      (rx_mode),
    .err_ind      (err_ind)
);

// File: tb/rx_chan_supervisor_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with every output each cycle.
module rx_chan_supervisor_tb;
    localparam int NCH  = 2;
    localparam int FAW  = 7;
    localparam int SW   = FAW - 4;
    localparam int HOLD = 1000;
    localparam int MAXQ = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   start = '0, stop = '0, rx_aligned = '0, rx_ovfl = '0;
    logic [NCH-1:0]   done_valid = '0, ring_ok = '0;
    logic [2*NCH-1:0] done_crc = '0;
    logic [FAW*NCH-1:0] ring_ofs = '0;
    logic             flag_rd = 1'b0;
    logic [0:0]       flag_rd_ch = '0;
    logic [NCH-1:0]   done_pop, ring_reserve, ring_commit, ring_flush, bd_push, ovfl_clr, rx_en;
    logic [SW*NCH-1:0] bd_slot;
    logic [2*NCH-1:0] rx_mode;
    logic [2:0]       flag_data;
    logic             err_ind;

    rx_chan_supervisor u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .rx_aligned(rx_aligned), .rx_ovfl(rx_ovfl),
        .done_valid(done_valid), .done_crc(done_crc), .done_pop(done_pop),
        .ring_ok(ring_ok), .ring_ofs(ring_ofs), .ring_reserve(ring_reserve),
        .ring_commit(ring_commit), .ring_flush(ring_flush),
        .bd_push(bd_push), .bd_slot(bd_slot), .rx_en(rx_en), .rx_mode(rx_mode),
        .ovfl_clr(ovfl_clr), .flag_rd(flag_rd), .flag_rd_ch(flag_rd_ch),
        .flag_data(flag_data), .err_ind(err_ind)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0;
    bit finished = 0;

    // Reference model state: 0 idle, 1 boot, 2 run, 3 recover.
    int m_st [NCH], m_inf [NCH], m_flg [NCH], m_en [NCH], m_mode [NCH];
    int n_st [NCH], n_inf [NCH], n_flg [NCH], n_en [NCH], n_mode [NCH];
    int m_rr, n_rr, m_err, n_err;
    logic [NCH-1:0] e_pop, e_res, e_com, e_fl, e_push, e_ovc;
    logic [SW*NCH-1:0] e_slot;

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compute expected outputs and next model state from model state and inputs.
    task automatic model_eval();
        logic any_err;
        any_err = 1'b0;
        e_pop = '0; e_res = '0; e_com = '0; e_fl = '0; e_push = '0; e_ovc = '0; e_slot = '0;
        for (int c = 0; c < NCH; c++) begin
            n_st[c] = m_st[c]; n_inf[c] = m_inf[c]; n_en[c] = m_en[c]; n_mode[c] = m_mode[c];
            n_flg[c] = (flag_rd && flag_rd_ch == c) ? 0 : m_flg[c];
            if (stop[c]) begin
                n_st[c] = 0; n_en[c] = 0; n_mode[c] = 0;
            end else if (start[c]) begin
                n_st[c] = 1; n_inf[c] = 0; n_flg[c] = 0; n_en[c] = 1; n_mode[c] = 3; e_ovc[c] = 1'b1;
            end else if (m_rr == c && m_st[c] != 0) begin
                if (done_valid[c]) begin
                    e_pop[c] = 1'b1; e_com[c] = 1'b1;
                    if (m_inf[c] > 0) n_inf[c] = m_inf[c] - 1;
                    if (done_crc[2*c +: 2] != 2'b11) begin n_flg[c] |= 4; any_err = 1'b1; end
                end else if (m_st[c] == 2 && !rx_aligned[c]) begin
                    n_st[c] = 3; n_flg[c] |= 1; any_err = 1'b1;
                end else if (m_st[c] == 2 && rx_ovfl[c]) begin
                    n_st[c] = 3; n_flg[c] |= 2;
                end else if (m_st[c] == 3) begin
                    if (m_inf[c] == 0) begin e_fl[c] = 1'b1; n_st[c] = 1; end
                end else if (m_inf[c] < MAXQ && ring_ok[c]) begin
                    e_res[c] = 1'b1; e_push[c] = 1'b1; n_inf[c] = m_inf[c] + 1;
                    e_slot[SW*c +: SW] = SW'(ring_ofs[FAW*c +: FAW] / 16);
                end else if (m_st[c] == 1) begin
                    e_ovc[c] = 1'b1; n_st[c] = 2;
                end
            end
        end
        n_rr  = (m_rr + 1) % NCH;
        n_err = any_err ? HOLD : (m_err > 0 ? m_err - 1 : 0);
    endtask

    // Compare every output with the model away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            model_eval();
            check("R2",  "done_pop",     done_pop,     e_pop);
            check("R2",  "ring_commit",  ring_commit,  e_com);
            check("R4",  "ring_flush",   ring_flush,   e_fl);
            check("R5",  "ring_reserve", ring_reserve, e_res);
            check("R5",  "bd_push",      bd_push,      e_push);
            check("R8",  "bd_slot",      bd_slot,      e_slot);
            check("R6",  "ovfl_clr",     ovfl_clr,     e_ovc);
            for (int c = 0; c < NCH; c++) begin
                check("R1", "rx_en",   rx_en[c],          m_en[c]);
                check("R1", "rx_mode", rx_mode[2*c +: 2], m_mode[c]);
            end
            check("R9",  "flag_data", flag_data, m_flg[flag_rd_ch]);
            check("R7",  "err_ind",   err_ind,   (m_err != 0) ? 1 : 0);
        end
    end

    // Advance the model at the edge (inputs change only #1 later).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rr = 0; m_err = 0;
            for (int c = 0; c < NCH; c++) begin
                m_st[c] = 0; m_inf[c] = 0; m_flg[c] = 0; m_en[c] = 0; m_mode[c] = 0;
            end
        end else begin
            model_eval();
            m_rr = n_rr; m_err = n_err;
            for (int c = 0; c < NCH; c++) begin
                m_st[c] = n_st[c]; m_inf[c] = n_inf[c]; m_flg[c] = n_flg[c];
                m_en[c] = n_en[c]; m_mode[c] = n_mode[c];
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic summary();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20ns * 20000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        // Reset state of the outputs.
        check("R1", "reset rx_en", rx_en, 0);
        check("R7", "reset err_ind", err_ind, 0);
        check("R5", "reset bd_push", bd_push, 0);
        rst_n = 1'b1;
        // R11: idle channels ignore completions and faults.
        done_valid = '1; rx_aligned = '0; rx_ovfl = '1;
        repeat (6) tick();
        check("R11", "idle no pop", done_pop, 0);
        // R1 start, then fill with the ring always available (R5, R6, R8).
        done_valid = '0; rx_ovfl = '0; rx_aligned = '1; ring_ok = '1; ring_ofs = {7'd83, 7'd37};
        start = '1; tick(); start = '0;
        repeat (30) tick();
        // Pseudo-random mix for R2, R3, R4, R7, R9, R10.
        for (int n = 0; n < 4000; n++) begin
            for (int c = 0; c < NCH; c++) begin
                rx_aligned[c] = ($urandom % 100) >= 4;
                rx_ovfl[c]    = ($urandom % 100) < 3;
                done_valid[c] = (m_inf[c] > 0) && (($urandom % 100) < 40);
                done_crc[2*c +: 2] = (($urandom % 100) < 80) ? 2'b11 : 2'($urandom);
                ring_ok[c]    = ($urandom % 100) < 80;
                ring_ofs[FAW*c +: FAW] = 7'($urandom);
                stop[c]       = ($urandom % 1000) < 4;
                start[c]      = ($urandom % 1000) < 6;
            end
            flag_rd    = ($urandom % 100) < 10;
            flag_rd_ch = 1'($urandom);
            tick();
        end
        // Quiet stretch: the hold time runs out (R7).
        start = '0; stop = '0; rx_ovfl = '0; rx_aligned = '1; done_valid = '0; flag_rd = 1'b0;
        repeat (HOLD + 50) tick();
        check("R7", "err_ind after quiet", err_ind, 0);
        // Stop both channels (R1).
        stop = '1; tick(); stop = '0; tick();
        check("R1", "rx_en after stop", rx_en, 0);
        summary();
    end
endmodule